// File: doc/BRIEF.md
# Line-Cached DRAM Bank Front-End

This block places a small fully associative line cache between a request port and a single DRAM-core bank. Each line is as wide as the internal core datapath, so a single core transfer always moves a complete line. Requests that hit are answered from the line store alone, and the core is never touched. A miss raises a keep-awake request toward the core. If the chosen victim holds modified data, that whole line is first written back. The missing line is then read in with one wide transfer, and the pending request completes against it.

When the fill has finished, the keep-awake request drops in the same cycle the response is presented. Power control can therefore put the core to sleep with no idle timeout. The line store is always active; only the core side is power managed. Replacement is least recently used across all lines, and lines are write-back with a dirty bit. One request is handled at a time.

Top module: `cdram_front`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `core_keep_awake` and `core_cmd_valid` are 0.
- R2: A read that hits returns the addressed word with `rsp_valid` in the cycle after acceptance. No core command is issued and `core_keep_awake` stays 0.
- R3: A write that hits replaces only the addressed word of its line and marks the line dirty. It is acknowledged with `rsp_valid` in the cycle after acceptance, and no core command is issued.
- R4: A miss raises `core_keep_awake` and `core_cmd_valid` in the cycle after acceptance. The command reads the missing block: `core_cmd_write`=0 and `core_cmd_blk` = address bits above the word offset. Read data is returned in the cycle after the fill's `core_done`.
- R5: `req_ready` is 0 from the cycle after a miss is accepted until the response of that miss is presented.
- R6: Any `NUM_LINES` distinct block addresses can be resident together, including blocks that share all low address bits.
- R7: When every line is valid, a miss replaces the least recently used line. Hits and fills both count as uses.
- R8: A dirty victim is written back in full before the fill. This is one command with `core_cmd_write`=1, `core_cmd_blk` equal to the victim's block and `core_wline` equal to the victim line. The fill read follows.
- R9: An invalid or clean victim is replaced with no write-back command.
- R10: `core_keep_awake` is 1 whenever a core command is outstanding. It falls in the cycle after the fill's `core_done`, in the same cycle as `rsp_valid` and the return of `req_ready`.
- R11: A write miss merges its word into the freshly filled line in the fill cycle. The other words of the line keep the core's data, and the line is dirty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low log2(LINE_W/DATA_W) bits select the word in a line |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data (echoes write data on writes) |
| core_keep_awake | output | 1 | Core must be powered; 0 means it may sleep |
| core_cmd_valid | output | 1 | Core transfer command outstanding |
| core_cmd_write | output | 1 | 1 = write line back, 0 = read line |
| core_cmd_blk | output | ADDR_W-log2(LINE_W/DATA_W) | Block address of the transfer |
| core_wline | output | LINE_W | Line written back to the core |
| core_done | input | 1 | One-cycle completion of the current command |
| core_rline | input | LINE_W | Line read from the core, valid with core_done |

## Verification
Two actions land in the same cycle: the fill completing and the pending write merging into the installed line. The bench provokes this with a write to a block that is not resident. It then reads the written word and a neighbouring word as hits. Later it forces that line out as the least recently used dirty victim, and compares the written-back line word by word against core data with the one merged word substituted. The same cycle also releases the core, and the bench judges this by sampling `core_keep_awake`, `rsp_valid` and `req_ready` together at the response.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } cdram_state_t;
endpackage

// File: rtl/cdram_tag_match.sv
module cdram_tag_match #(
  parameter int N  = 8,
  parameter int BW = 12,
  parameter int IW = 3
) (
  input  logic [N-1:0][BW-1:0] tags,
  input  logic [N-1:0]         valid,
  input  logic [BW-1:0]        blk,
  output logic                 hit,
  output logic [IW-1:0]        hit_idx,
  output logic                 free,
  output logic [IW-1:0]        free_idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == blk);
  end

  // lowest index wins for both searches
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
      if (!valid[i]) free_idx = IW'(i);
    end
  end

  assign hit  = |match;
  assign free = ~&valid;
endmodule

// File: rtl/cdram_lru.sv
module cdram_lru #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest_idx
);
  // ages always form a permutation of 0..N-1; N-1 marks the oldest line
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == IW'(N - 1)) oldest_idx = IW'(i);
  end
endmodule

// File: rtl/cdram_line_store.sv
module cdram_line_store #(
  parameter int N  = 8,
  parameter int LW = 512,
  parameter int DW = 32,
  parameter int IW = 3,
  localparam int WORDS = LW / DW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [WORDS-1:0] wmask,
  input  logic [LW-1:0]    wdata,
  input  logic [IW-1:0]    ridx,
  output logic [LW-1:0]    rdata
);
  logic [LW-1:0] mem_q [N];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++)
      if (we && wmask[w]) mem_q[widx][w*DW +: DW] <= wdata[w*DW +: DW];
  end

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/cdram_front.sv
module cdram_front #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int LINE_W    = 512,
  parameter int NUM_LINES = 8
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          req_valid,
  output logic                                          req_ready,
  input  logic                                          req_write,
  input  logic [ADDR_W-1:0]                             req_addr,
  input  logic [DATA_W-1:0]                             req_wdata,
  output logic                                          rsp_valid,
  output logic [DATA_W-1:0]                             rsp_rdata,
  output logic                                          core_keep_awake,
  output logic                                          core_cmd_valid,
  output logic                                          core_cmd_write,
  output logic [ADDR_W-$clog2(LINE_W/DATA_W)-1:0]       core_cmd_blk,
  output logic [LINE_W-1:0]                             core_wline,
  input  logic                                          core_done,
  input  logic [LINE_W-1:0]                             core_rline
);
  import cdram_pkg::*;

  localparam int WORDS = LINE_W / DATA_W;
  localparam int OFF_W = $clog2(WORDS);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(NUM_LINES);

  cdram_state_t state_q;
  logic [NUM_LINES-1:0][BLK_W-1:0] tags_q;
  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic                 pend_write_q;
  logic [OFF_W-1:0]     pend_off_q;
  logic [DATA_W-1:0]    pend_wdata_q;
  logic [BLK_W-1:0]     pend_blk_q;
  logic [IDX_W-1:0]     vidx_q;

  logic [BLK_W-1:0] req_blk;
  logic [OFF_W-1:0] req_off;
  logic hit, free, accept, hit_acc, miss_acc, fill_done;
  logic [IDX_W-1:0] hit_idx, free_idx, oldest_idx, victim_idx;
  logic [IDX_W-1:0] rd_idx, wr_idx, touch_idx;
  logic [LINE_W-1:0] rd_line, wr_line, fill_line;
  logic [WORDS-1:0]  wr_mask;
  logic wr_en, touch;

  assign req_blk  = req_addr[ADDR_W-1:OFF_W];
  assign req_off  = req_addr[OFF_W-1:0];
  assign req_ready = (state_q == ST_IDLE);
  assign accept   = req_valid && req_ready;
  assign hit_acc  = accept && hit;
  assign miss_acc = accept && !hit;
  assign fill_done = (state_q == ST_FILL) && core_done;

  cdram_tag_match #(.N(NUM_LINES), .BW(BLK_W), .IW(IDX_W)) u_match (
    .tags(tags_q), .valid(valid_q), .blk(req_blk),
    .hit(hit), .hit_idx(hit_idx), .free(free), .free_idx(free_idx)
  );

  assign touch     = hit_acc || fill_done;
  assign touch_idx = hit_acc ? hit_idx : vidx_q;

  cdram_lru #(.N(NUM_LINES), .IW(IDX_W)) u_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .oldest_idx(oldest_idx)
  );

  assign victim_idx = free ? free_idx : oldest_idx;
  assign rd_idx     = hit ? hit_idx : victim_idx;

  // fill data with the pending write word folded in
  always_comb begin
    fill_line = core_rline;
    if (pend_write_q) fill_line[pend_off_q*DATA_W +: DATA_W] = pend_wdata_q;
  end

  assign wr_en   = (hit_acc && req_write) || fill_done;
  assign wr_idx  = hit_acc ? hit_idx : vidx_q;
  assign wr_mask = hit_acc ? (WORDS'(1) << req_off) : {WORDS{1'b1}};
  assign wr_line = hit_acc ? {WORDS{req_wdata}} : fill_line;

  cdram_line_store #(.N(NUM_LINES), .LW(LINE_W), .DW(DATA_W), .IW(IDX_W)) u_store (
    .clk(clk), .we(wr_en), .widx(wr_idx), .wmask(wr_mask), .wdata(wr_line),
    .ridx(rd_idx), .rdata(rd_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_IDLE;
      tags_q          <= '0;
      valid_q         <= '0;
      dirty_q         <= '0;
      pend_write_q    <= 1'b0;
      pend_off_q      <= '0;
      pend_wdata_q    <= '0;
      pend_blk_q      <= '0;
      vidx_q          <= '0;
      rsp_valid       <= 1'b0;
      rsp_rdata       <= '0;
      core_keep_awake <= 1'b0;
      core_cmd_valid  <= 1'b0;
      core_cmd_write  <= 1'b0;
      core_cmd_blk    <= '0;
      core_wline      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hit_acc) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= req_write ? req_wdata : rd_line[req_off*DATA_W +: DATA_W];
            if (req_write) dirty_q[hit_idx] <= 1'b1;
          end else if (miss_acc) begin
            pend_write_q    <= req_write;
            pend_off_q      <= req_off;
            pend_wdata_q    <= req_wdata;
            pend_blk_q      <= req_blk;
            vidx_q          <= victim_idx;
            core_keep_awake <= 1'b1;
            core_cmd_valid  <= 1'b1;
            if (valid_q[victim_idx] && dirty_q[victim_idx]) begin
              core_cmd_write <= 1'b1;
              core_cmd_blk   <= tags_q[victim_idx];
              core_wline     <= rd_line;
              state_q        <= ST_WBACK;
            end else begin
              core_cmd_write <= 1'b0;
              core_cmd_blk   <= req_blk;
              state_q        <= ST_FILL;
            end
          end
        end
        ST_WBACK: begin
          if (core_done) begin
            core_cmd_write  <= 1'b0;
            core_cmd_blk    <= pend_blk_q;
            dirty_q[vidx_q] <= 1'b0;
            state_q         <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (core_done) begin
            core_cmd_valid  <= 1'b0;
            core_keep_awake <= 1'b0;
            tags_q[vidx_q]  <= pend_blk_q;
            valid_q[vidx_q] <= 1'b1;
            dirty_q[vidx_q] <= pend_write_q;
            rsp_valid       <= 1'b1;
            rsp_rdata       <= pend_write_q ? pend_wdata_q
                                            : core_rline[pend_off_q*DATA_W +: DATA_W];
            state_q         <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cdram_front_chk.sv
module cdram_front_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic hit,
  input logic rsp_valid,
  input logic core_keep_awake,
  input logic core_cmd_valid,
  input logic core_cmd_write,
  input logic core_done
);
  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && hit) |=> (rsp_valid && !core_cmd_valid && !core_keep_awake));

  // R4
  miss_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !hit) |=> (core_keep_awake && core_cmd_valid && !rsp_valid));

  // R5
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    core_keep_awake |-> !req_ready);

  // R8
  wback_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (core_cmd_valid && core_cmd_write && core_done) |=>
      (core_cmd_valid && !core_cmd_write && core_keep_awake));

  // R10
  awake_covers_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    core_cmd_valid |-> core_keep_awake);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (core_cmd_valid && !core_cmd_write && core_done) |=>
      (!core_keep_awake && rsp_valid && req_ready));
endmodule

bind cdram_front cdram_front_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .hit(hit),
  .rsp_valid(rsp_valid), .core_keep_awake(core_keep_awake),
  .core_cmd_valid(core_cmd_valid), .core_cmd_write(core_cmd_write),
  .core_done(core_done)
);

// File: tb/cdram_front_bench.sv
module cdram_front_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LINE_W = 512;
  localparam int NLINES = 8;
  localparam int WORDS  = LINE_W / DATA_W;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, core_keep_awake, core_cmd_valid, core_cmd_write;
  logic [DATA_W-1:0] rsp_rdata;
  logic [BLK_W-1:0]  core_cmd_blk;
  logic [LINE_W-1:0] core_wline;
  logic core_done = 1'b0;
  logic [LINE_W-1:0] core_rline = '0;

  int total = 0, bad = 0;
  int n_rd = 0, n_wr = 0;
  logic [BLK_W-1:0]  last_wr_blk = '0;
  logic [LINE_W-1:0] last_wr_line = '0;
  logic [LINE_W-1:0] wb_store [int];
  bit finished = 0;

  always #10 clk = ~clk;

  cdram_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W), .NUM_LINES(NLINES))
  u_cdram_front (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .core_keep_awake(core_keep_awake),
    .core_cmd_valid(core_cmd_valid), .core_cmd_write(core_cmd_write),
    .core_cmd_blk(core_cmd_blk), .core_wline(core_wline), .core_done(core_done),
    .core_rline(core_rline)
  );

  function automatic logic [DATA_W-1:0] pat(input logic [BLK_W-1:0] b, input int w);
    return 32'hC000_0000 | (32'(b) << 8) | 32'(w);
  endfunction

  function automatic logic [DATA_W-1:0] core_word(input logic [BLK_W-1:0] b, input int w);
    if (wb_store.exists(int'(b))) return wb_store[int'(b)][w*DATA_W +: DATA_W];
    return pat(b, w);
  endfunction

  // behavioural core: fixed latency, one-cycle done strobe
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (core_done) begin
        core_done = 1'b0;
        cnt = 0;
      end else if (core_cmd_valid) begin
        cnt++;
        if (cnt == LAT) begin
          if (core_cmd_write) begin
            n_wr++;
            last_wr_blk  = core_cmd_blk;
            last_wr_line = core_wline;
            wb_store[int'(core_cmd_blk)] = core_wline;
          end else begin
            n_rd++;
            for (int w = 0; w < WORDS; w++)
              core_rline[w*DATA_W +: DATA_W] = core_word(core_cmd_blk, w);
          end
          core_done = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one request starting at a negedge; returns data, latency and busy/release flags
  task automatic do_req(input logic w, input logic [BLK_W-1:0] b, input int off,
                        input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] rd,
                        output int lat, output bit busy_ok, output bit rel_ok);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = {b, OFF_W'(off)};
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_ok = 1;
    while (!rsp_valid && lat < 100) begin
      if (!(core_keep_awake && !req_ready)) busy_ok = 0;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    rel_ok = !core_keep_awake && req_ready && rsp_valid;
    @(negedge clk);
  endtask

  logic [DATA_W-1:0] rd;
  int lat, r0, w0;
  bit busy_ok, rel_ok;
  logic [BLK_W-1:0] blks [NLINES];

  task automatic t_reset();
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 keep_awake", 64'(core_keep_awake), 64'd0);
    chk("R1 cmd_valid", 64'(core_cmd_valid), 64'd0);
  endtask

  task automatic t_cold_miss();
    r0 = n_rd; w0 = n_wr;
    do_req(1'b0, 12'h010, 3, '0, rd, lat, busy_ok, rel_ok);
    chk("R4 data", 64'(rd), 64'(pat(12'h010, 3)));
    chk("R4 latency", 64'(lat), 64'(LAT + 1));
    chk("R4 one read", 64'(n_rd - r0), 64'd1);
    chk("R9 no writeback", 64'(n_wr - w0), 64'd0);
    chk("R5 busy not ready", 64'(busy_ok), 64'd1);
    chk("R10 release", 64'(rel_ok), 64'd1);
  endtask

  task automatic t_hit();
    r0 = n_rd;
    do_req(1'b0, 12'h010, 9, '0, rd, lat, busy_ok, rel_ok);
    chk("R2 data", 64'(rd), 64'(pat(12'h010, 9)));
    chk("R2 latency", 64'(lat), 64'd1);
    chk("R2 no core", 64'(n_rd - r0), 64'd0);
    chk("R2 awake low", 64'(rel_ok), 64'd1);
  endtask

  task automatic t_write_hit();
    r0 = n_rd; w0 = n_wr;
    do_req(1'b1, 12'h010, 5, 32'hDEAD_0005, rd, lat, busy_ok, rel_ok);
    chk("R3 ack latency", 64'(lat), 64'd1);
    chk("R3 no core", 64'((n_rd - r0) + (n_wr - w0)), 64'd0);
    do_req(1'b0, 12'h010, 5, '0, rd, lat, busy_ok, rel_ok);
    chk("R3 readback", 64'(rd), 64'h0000_0000_DEAD_0005);
    do_req(1'b0, 12'h010, 4, '0, rd, lat, busy_ok, rel_ok);
    chk("R3 neighbour kept", 64'(rd), 64'(pat(12'h010, 4)));
  endtask

  task automatic t_write_miss();
    r0 = n_rd;
    do_req(1'b1, 12'h020, 7, 32'hBEEF_0007, rd, lat, busy_ok, rel_ok);
    chk("R11 latency", 64'(lat), 64'(LAT + 1));
    chk("R11 one read", 64'(n_rd - r0), 64'd1);
    chk("R11 release", 64'(rel_ok), 64'd1);
    do_req(1'b0, 12'h020, 7, '0, rd, lat, busy_ok, rel_ok);
    chk("R11 merged word", 64'(rd), 64'h0000_0000_BEEF_0007);
    chk("R11 merged word hit", 64'(lat), 64'd1);
    do_req(1'b0, 12'h020, 6, '0, rd, lat, busy_ok, rel_ok);
    chk("R11 core word kept", 64'(rd), 64'(pat(12'h020, 6)));
  endtask

  task automatic t_fill_all();
    blks[0] = 12'h010; blks[1] = 12'h020;
    for (int i = 2; i < NLINES; i++) blks[i] = BLK_W'(((i - 1) << 8) | 12'h010);
    w0 = n_wr;
    for (int i = 2; i < NLINES; i++)
      do_req(1'b0, blks[i], 1, '0, rd, lat, busy_ok, rel_ok);
    chk("R9 fills into free lines", 64'(n_wr - w0), 64'd0);
    r0 = n_rd;
    for (int i = 0; i < NLINES; i++) begin
      do_req(1'b0, blks[i], 2, '0, rd, lat, busy_ok, rel_ok);
      chk("R6 resident", 64'(lat), 64'd1);
      chk("R6 data", 64'(rd), 64'(core_word(blks[i], 2)));
    end
    chk("R6 no reads", 64'(n_rd - r0), 64'd0);
  endtask

  task automatic t_evict();
    logic [LINE_W-1:0] exp_line;
    // make 0x010 recent so dirty 0x020 is least recently used
    do_req(1'b0, 12'h010, 0, '0, rd, lat, busy_ok, rel_ok);
    r0 = n_rd; w0 = n_wr;
    do_req(1'b0, 12'h700, 2, '0, rd, lat, busy_ok, rel_ok);
    chk("R8 latency", 64'(lat), 64'(2 * LAT + 2));
    chk("R8 one writeback", 64'(n_wr - w0), 64'd1);
    chk("R8 one read", 64'(n_rd - r0), 64'd1);
    chk("R8 victim block", 64'(last_wr_blk), 64'h020);
    for (int w = 0; w < WORDS; w++) exp_line[w*DATA_W +: DATA_W] = pat(12'h020, w);
    exp_line[7*DATA_W +: DATA_W] = 32'hBEEF_0007;
    total++;
    if (last_wr_line !== exp_line) begin
      bad++;
      $display("FAIL R11 written-back line actual=%h expected=%h", last_wr_line, exp_line);
    end
    chk("R8 new data", 64'(rd), 64'(pat(12'h700, 2)));
    chk("R5 busy during writeback", 64'(busy_ok), 64'd1);
    chk("R10 release after two transfers", 64'(rel_ok), 64'd1);
    do_req(1'b0, 12'h010, 5, '0, rd, lat, busy_ok, rel_ok);
    chk("R7 recent line kept", 64'(lat), 64'd1);
    chk("R7 recent line data", 64'(rd), 64'h0000_0000_DEAD_0005);
    // next LRU is clean 0x110
    r0 = n_rd; w0 = n_wr;
    do_req(1'b0, 12'h800, 0, '0, rd, lat, busy_ok, rel_ok);
    chk("R9 clean victim latency", 64'(lat), 64'(LAT + 1));
    chk("R9 clean victim no writeback", 64'(n_wr - w0), 64'd0);
    do_req(1'b0, 12'h110, 1, '0, rd, lat, busy_ok, rel_ok);
    chk("R7 LRU line was evicted", 64'(lat), 64'(LAT + 1));
    do_req(1'b0, 12'h020, 7, '0, rd, lat, busy_ok, rel_ok);
    chk("R8 data survives round trip", 64'(rd), 64'h0000_0000_BEEF_0007);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_hit();
    t_write_hit();
    t_write_miss();
    t_fill_all();
    t_evict();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule